// File: doc/BRIEF.md
# Legacy Peripheral Resource Decoder

This block turns three 8-bit configuration bytes into the resource map of six legacy I/O functions: a parallel port, two serial ports, a floppy controller, and the primary and secondary windows of a disk controller. For each function it produces the I/O base address and the interrupt number. It then compares a 10-bit bus I/O address against every enabled window and drives a one-hot chip select. If no window claims the address, it raises a no-match flag.

The block is purely combinational and holds no state. The configuration bytes are expected to come from registers elsewhere in the chip. The bus address is decoded in the same cycle it is presented. Where two enabled windows overlap, a fixed priority picks exactly one function, so the one-hot property holds for every setting. One such overlap is the secondary disk window landing inside the floppy window.

Top module: `lrd_decoder`

## Requirements
- R1: Enable byte bits select the functions: bit 0 parallel, bit 1 serial 1, bit 2 serial 2, bit 3 floppy, bit 6 disk (both windows). A disabled function never asserts its chip select, and neither does a parallel port whose address code is 3.
- R2: The parallel address code is address byte bits [1:0]. Codes 0, 1, 2 and 3 give bases 0x378, 0x3BC, 0x278 and 0 (none).
- R3: The parallel interrupt is 7 for code 1, 5 for code 2 and 0 for code 3. For code 0 it is 7 when power/test byte bit 3 is set and 5 when that bit is clear.
- R4: Serial port n (n = 1, 2) takes its 2-bit code from address byte bits [2n+1:2n]. Code 0 gives base 0x3F8 and code 1 gives base 0x2F8.
- R5: For serial codes 2 and 3, the base depends on code bit 0 and the shared set field, address byte bits [7:6], taking set values 0, 1, 2 and 3 in that order. Code 2 gives 0x3E8, 0x338, 0x2E8 or 0x220. Code 3 gives 0x2E8, 0x238, 0x2E0 or 0x228.
- R6: A serial interrupt is 3 for an odd code and 4 for an even code.
- R7: The floppy base is 0x370 when enable bit 5 is set and 0x3F0 when it is clear. The floppy interrupt is always 6.
- R8: The disk primary base is 0x170 when enable bit 7 is set and 0x1F0 when it is clear. The secondary base is the primary base plus 0x206. The disk interrupt is always 14.
- R9: Every window covers 8 bytes from its base, except the disk secondary window, which covers 1 byte. Chip-select bits are [0] parallel, [1] serial 1, [2] serial 2, [3] floppy, [4] disk primary, [5] disk secondary.
- R10: When several enabled windows contain the address, only the lowest-numbered chip-select bit is asserted.
- R11: The no-match flag is high exactly when no chip select is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| en_reg_i | input | 8 | Function enable and alternate-address byte |
| addr_reg_i | input | 8 | Parallel/serial address code byte |
| pwr_reg_i | input | 8 | Power/test byte (bit 3 used) |
| io_addr_i | input | 10 | Bus I/O address to decode |
| par_base_o | output | 10 | Parallel base (0 = none) |
| par_irq_o | output | 4 | Parallel interrupt number |
| ser1_base_o | output | 10 | Serial 1 base |
| ser1_irq_o | output | 4 | Serial 1 interrupt number |
| ser2_base_o | output | 10 | Serial 2 base |
| ser2_irq_o | output | 4 | Serial 2 interrupt number |
| fdc_base_o | output | 10 | Floppy base |
| fdc_irq_o | output | 4 | Floppy interrupt number |
| dsk_base_o | output | 10 | Disk primary base |
| dsk_alt_base_o | output | 10 | Disk secondary base |
| dsk_irq_o | output | 4 | Disk interrupt number |
| cs_o | output | 6 | One-hot chip selects |
| nomatch_o | output | 1 | No enabled window claims the address |

## Verification
The assertions are immediate checks on settled combinational values. They assume every input is a known 0 or 1 and that all bases fit in the 10-bit address space. No base plus its window size wraps past 0x3FF, so a window comparison never overflows. The stimulus only drives fully specified bytes and addresses. It picks addresses at window edges, one byte inside and one byte outside each window, and it builds overlaps on purpose from legal codes, so every input stays within those assumptions.

// File: rtl/lrd_pkg.sv
package lrd_pkg;
  localparam int ADDR_W = 10;
  localparam int IRQ_W  = 4;
  localparam int FN_NUM = 6;

  localparam int FN_PAR  = 0;
  localparam int FN_SER1 = 1;
  localparam int FN_SER2 = 2;
  localparam int FN_FDC  = 3;
  localparam int FN_DSK  = 4;
  localparam int FN_DSK2 = 5;

  // second-level serial table: odd selects the column, set selects the row
  function automatic logic [ADDR_W-1:0] ser_alt_base(input logic odd, input logic [1:0] set);
    logic [ADDR_W-1:0] b;
    unique case ({odd, set})
      3'b000: b = 10'h3E8;
      3'b001: b = 10'h338;
      3'b010: b = 10'h2E8;
      3'b011: b = 10'h220;
      3'b100: b = 10'h2E8;
      3'b101: b = 10'h238;
      3'b110: b = 10'h2E0;
      default: b = 10'h228;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/lrd_lpt_decode.sv
module lrd_lpt_decode
  import lrd_pkg::*;
(
  input  logic [1:0]        code_i,
  input  logic              irq_hi_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [IRQ_W-1:0]  irq_o,
  output logic              valid_o
);
  always_comb begin
    valid_o = 1'b1;
    unique case (code_i)
      2'd0: begin base_o = 10'h378; irq_o = irq_hi_i ? 4'd7 : 4'd5; end
      2'd1: begin base_o = 10'h3BC; irq_o = 4'd7; end
      2'd2: begin base_o = 10'h278; irq_o = 4'd5; end
      default: begin base_o = '0; irq_o = '0; valid_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/lrd_uart_decode.sv
module lrd_uart_decode
  import lrd_pkg::*;
(
  input  logic [1:0]        code_i,
  input  logic [1:0]        set_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [IRQ_W-1:0]  irq_o
);
  always_comb begin
    unique case (code_i)
      2'd0:    base_o = 10'h3F8;
      2'd1:    base_o = 10'h2F8;
      default: base_o = ser_alt_base(code_i[0], set_i);
    endcase
    irq_o = code_i[0] ? 4'd3 : 4'd4;
  end
endmodule

// File: rtl/lrd_window.sv
module lrd_window #(
  parameter int ADDR_W = 10,
  parameter int SIZE   = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              en_i,
  output logic              hit_o
);
  localparam logic [ADDR_W:0] SIZE_EXT = (ADDR_W+1)'(SIZE);
  logic [ADDR_W:0] off;
  // extra bit keeps addresses below base out of the window
  assign off   = {1'b0, addr_i} - {1'b0, base_i};
  assign hit_o = en_i && !off[ADDR_W] && (off < SIZE_EXT);
endmodule

// File: rtl/lrd_prio.sv
module lrd_prio #(
  parameter int N = 6
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         none_o
);
  assign grant_o = req_i & (~req_i + N'(1));
  assign none_o  = ~|req_i;
endmodule

// File: rtl/lrd_decoder.sv
module lrd_decoder
  import lrd_pkg::*;
#(
  parameter int WIN_BYTES = 8,
  parameter int ALT_WIN_BYTES = 1,
  parameter logic [ADDR_W-1:0] DSK_ALT_OFS = 10'h206
) (
  input  logic [7:0]        en_reg_i,
  input  logic [7:0]        addr_reg_i,
  input  logic [7:0]        pwr_reg_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  output logic [ADDR_W-1:0] par_base_o,
  output logic [IRQ_W-1:0]  par_irq_o,
  output logic [ADDR_W-1:0] ser1_base_o,
  output logic [IRQ_W-1:0]  ser1_irq_o,
  output logic [ADDR_W-1:0] ser2_base_o,
  output logic [IRQ_W-1:0]  ser2_irq_o,
  output logic [ADDR_W-1:0] fdc_base_o,
  output logic [IRQ_W-1:0]  fdc_irq_o,
  output logic [ADDR_W-1:0] dsk_base_o,
  output logic [ADDR_W-1:0] dsk_alt_base_o,
  output logic [IRQ_W-1:0]  dsk_irq_o,
  output logic [FN_NUM-1:0] cs_o,
  output logic              nomatch_o
);
  localparam int NUM_SER = 2;

  logic                    par_valid;
  logic [ADDR_W-1:0]       ser_base [NUM_SER];
  logic [IRQ_W-1:0]        ser_irq  [NUM_SER];
  logic [ADDR_W-1:0]       fn_base  [FN_NUM];
  logic [FN_NUM-1:0]       fn_en;
  logic [FN_NUM-1:0]       fn_hit;

  lrd_lpt_decode u_lpt (
    .code_i   (addr_reg_i[1:0]),
    .irq_hi_i (pwr_reg_i[3]),
    .base_o   (par_base_o),
    .irq_o    (par_irq_o),
    .valid_o  (par_valid)
  );

  for (genvar s = 0; s < NUM_SER; s++) begin : g_ser
    lrd_uart_decode u_uart (
      .code_i (addr_reg_i[2*s+3:2*s+2]),
      .set_i  (addr_reg_i[7:6]),
      .base_o (ser_base[s]),
      .irq_o  (ser_irq[s])
    );
  end

  assign ser1_base_o    = ser_base[0];
  assign ser1_irq_o     = ser_irq[0];
  assign ser2_base_o    = ser_base[1];
  assign ser2_irq_o     = ser_irq[1];
  assign fdc_base_o     = en_reg_i[5] ? 10'h370 : 10'h3F0;
  assign fdc_irq_o      = 4'd6;
  assign dsk_base_o     = en_reg_i[7] ? 10'h170 : 10'h1F0;
  assign dsk_alt_base_o = dsk_base_o + DSK_ALT_OFS;
  assign dsk_irq_o      = 4'd14;

  assign fn_base[FN_PAR]  = par_base_o;
  assign fn_base[FN_SER1] = ser_base[0];
  assign fn_base[FN_SER2] = ser_base[1];
  assign fn_base[FN_FDC]  = fdc_base_o;
  assign fn_base[FN_DSK]  = dsk_base_o;
  assign fn_base[FN_DSK2] = dsk_alt_base_o;

  assign fn_en[FN_PAR]  = en_reg_i[0] & par_valid;
  assign fn_en[FN_SER1] = en_reg_i[1];
  assign fn_en[FN_SER2] = en_reg_i[2];
  assign fn_en[FN_FDC]  = en_reg_i[3];
  assign fn_en[FN_DSK]  = en_reg_i[6];
  assign fn_en[FN_DSK2] = en_reg_i[6];

  for (genvar f = 0; f < FN_NUM; f++) begin : g_win
    localparam int SZ = (f == FN_DSK2) ? ALT_WIN_BYTES : WIN_BYTES;
    lrd_window #(.ADDR_W(ADDR_W), .SIZE(SZ)) u_win (
      .addr_i (io_addr_i),
      .base_i (fn_base[f]),
      .en_i   (fn_en[f]),
      .hit_o  (fn_hit[f])
    );
  end

  lrd_prio #(.N(FN_NUM)) u_prio (
    .req_i   (fn_hit),
    .grant_o (cs_o),
    .none_o  (nomatch_o)
  );
endmodule

// File: rtl/lrd_checker.sv
module lrd_checker
  import lrd_pkg::*;
(
  input logic [7:0]        en_reg_i,
  input logic [7:0]        addr_reg_i,
  input logic [7:0]        pwr_reg_i,
  input logic [ADDR_W-1:0] io_addr_i,
  input logic [ADDR_W-1:0] par_base_o,
  input logic [IRQ_W-1:0]  par_irq_o,
  input logic [ADDR_W-1:0] ser1_base_o,
  input logic [IRQ_W-1:0]  ser1_irq_o,
  input logic [ADDR_W-1:0] ser2_base_o,
  input logic [IRQ_W-1:0]  ser2_irq_o,
  input logic [ADDR_W-1:0] fdc_base_o,
  input logic [IRQ_W-1:0]  fdc_irq_o,
  input logic [ADDR_W-1:0] dsk_base_o,
  input logic [ADDR_W-1:0] dsk_alt_base_o,
  input logic [IRQ_W-1:0]  dsk_irq_o,
  input logic [FN_NUM-1:0] cs_o,
  input logic              nomatch_o
);
  always_comb begin
    AST_CS_ONEHOT: assert ($onehot0(cs_o)); // R10
    AST_NOMATCH_EXACT: assert (nomatch_o == (cs_o == '0)); // R11
    AST_PAR_GATED: assert (!cs_o[FN_PAR] || (en_reg_i[0] && addr_reg_i[1:0] != 2'd3)); // R1
    AST_DSK_GATED: assert (!(cs_o[FN_DSK] || cs_o[FN_DSK2]) || en_reg_i[6]); // R1
    AST_SER2_IRQ: assert (ser2_irq_o == (addr_reg_i[4] ? 4'd3 : 4'd4)); // R6
    AST_FDC_WIN: assert (!cs_o[FN_FDC] || (io_addr_i >= fdc_base_o && io_addr_i - fdc_base_o < 10'd8)); // R9
    AST_DSK2_WIN: assert (!cs_o[FN_DSK2] || io_addr_i == dsk_alt_base_o); // R9
    AST_DSK_ALT_OFS: assert (dsk_alt_base_o - dsk_base_o == 10'h206); // R8
  end
endmodule

bind lrd_decoder lrd_checker u_lrd_checker (.*);

// File: tb/lrd_decoder_tb.sv
module lrd_decoder_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [7:0] en_r, addr_r, pwr_r;
  logic [9:0] io_a;
  logic [9:0] par_base, ser1_base, ser2_base, fdc_base, dsk_base, dsk_alt;
  logic [3:0] par_irq, ser1_irq, ser2_irq, fdc_irq, dsk_irq;
  logic [5:0] cs;
  logic       nomatch;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  lrd_decoder dut_i (
    .en_reg_i(en_r), .addr_reg_i(addr_r), .pwr_reg_i(pwr_r), .io_addr_i(io_a),
    .par_base_o(par_base), .par_irq_o(par_irq),
    .ser1_base_o(ser1_base), .ser1_irq_o(ser1_irq),
    .ser2_base_o(ser2_base), .ser2_irq_o(ser2_irq),
    .fdc_base_o(fdc_base), .fdc_irq_o(fdc_irq),
    .dsk_base_o(dsk_base), .dsk_alt_base_o(dsk_alt), .dsk_irq_o(dsk_irq),
    .cs_o(cs), .nomatch_o(nomatch)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] e, input logic [7:0] a, input logic [7:0] p, input logic [9:0] io);
    @(negedge clk);
    en_r = e; addr_r = a; pwr_r = p; io_a = io;
    #2;
  endtask

  function automatic int m_ser(input int code, input int set);
    if (code == 0) return 'h3F8;
    if (code == 1) return 'h2F8;
    if (code == 2) case (set) 0: return 'h3E8; 1: return 'h338; 2: return 'h2E8; default: return 'h220; endcase
    case (set) 0: return 'h2E8; 1: return 'h238; 2: return 'h2E0; default: return 'h228; endcase
  endfunction

  task automatic t_reset;
    drive(8'h00, 8'h00, 8'h00, 10'h3F8);
    chk("R1 all off cs", cs, 0);
    chk("R11 all off nomatch", nomatch, 1);
    chk("R7 fdc irq", fdc_irq, 6);
    chk("R8 dsk irq", dsk_irq, 14);
  endtask

  task automatic t_parallel;
    int bases[4] = '{'h378, 'h3BC, 'h278, 0};
    int irqs[4]  = '{5, 7, 5, 0};
    for (int c = 0; c < 4; c++) begin
      drive(8'h01, 8'(c), 8'h00, 10'(bases[c] + 7));
      chk("R2 par base", par_base, bases[c]);
      chk("R3 par irq", par_irq, irqs[c]);
      chk("R9 par last byte", cs, (c == 3) ? 0 : 1);
      drive(8'h01, 8'(c), 8'h08, 10'(bases[c] + 8));
      chk("R3 par irq bit3", par_irq, (c == 0) ? 7 : irqs[c]);
      chk("R9 par past end", cs, 0);
    end
    drive(8'h01, 8'h03, 8'h00, 10'h000);
    chk("R1 par none silent", cs, 0);
    drive(8'h00, 8'h00, 8'h00, 10'h378);
    chk("R1 par disabled", cs, 0);
    chk("R11 par disabled nomatch", nomatch, 1);
  endtask

  task automatic t_serial;
    for (int s = 0; s < 4; s++)
      for (int c1 = 0; c1 < 4; c1++) begin
        int c2 = 3 - c1;
        int b1 = m_ser(c1, s);
        logic [7:0] ar = 8'((s << 6) | (c2 << 4) | (c1 << 2));
        drive(8'h02, ar, 8'h00, 10'(b1));
        chk((c1 < 2) ? "R4 ser1 base" : "R5 ser1 base", ser1_base, b1);
        chk((c2 < 2) ? "R4 ser2 base" : "R5 ser2 base", ser2_base, m_ser(c2, s));
        chk("R6 ser1 irq", ser1_irq, (c1 & 1) ? 3 : 4);
        chk("R6 ser2 irq", ser2_irq, (c2 & 1) ? 3 : 4);
        chk("R9 ser1 hit", cs, 2);
        drive(8'h04, ar, 8'h00, 10'(b1));
        chk("R1 ser1 off", cs[1], 0);
      end
    drive(8'h06, 8'h00, 8'h00, 10'h3FF);
    chk("R10 ser1 beats ser2", cs, 2);
    drive(8'h04, 8'h00, 8'h00, 10'h3F7);
    chk("R9 ser2 below base", cs, 0);
  endtask

  task automatic t_fdc_disk;
    drive(8'h08, 8'h00, 8'h00, 10'h3F0);
    chk("R7 fdc base", fdc_base, 'h3F0);
    chk("R9 fdc hit", cs, 8);
    drive(8'h28, 8'h00, 8'h00, 10'h377);
    chk("R7 fdc alt base", fdc_base, 'h370);
    chk("R9 fdc alt hit", cs, 8);
    drive(8'h40, 8'h00, 8'h00, 10'h1F7);
    chk("R8 dsk base", dsk_base, 'h1F0);
    chk("R8 dsk alt base", dsk_alt, 'h3F6);
    chk("R9 dsk hit", cs, 16);
    drive(8'h40, 8'h00, 8'h00, 10'h3F6);
    chk("R9 dsk2 hit", cs, 32);
    drive(8'h40, 8'h00, 8'h00, 10'h3F7);
    chk("R9 dsk2 one byte", cs, 0);
    chk("R11 dsk2 miss", nomatch, 1);
    drive(8'hC0, 8'h00, 8'h00, 10'h376);
    chk("R8 dsk alt primary", dsk_base, 'h170);
    chk("R8 dsk2 alt", dsk_alt, 'h376);
    chk("R9 dsk2 alt hit", cs, 32);
    drive(8'h48, 8'h00, 8'h00, 10'h3F6);
    chk("R10 fdc beats dsk2", cs, 8);
    chk("R11 overlap matched", nomatch, 0);
    drive(8'h08, 8'h00, 8'h00, 10'h1F0);
    chk("R1 dsk disabled", cs, 0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    en_r = '0; addr_r = '0; pwr_r = '0; io_a = '0;
    t_reset();
    t_parallel();
    t_serial();
    t_fdc_disk();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule